// File: doc/BRIEF.md
# Dual-Port Memory with Atomic Conditional Update

This block is a small synchronous memory shared by two requesters. Each port can read a word, write a word, or run an atomic test-and-set. A test-and-set carries an address, a compare word and a set word. The block captures the stored word. If the stored word equals the compare word, the block writes the set word. It then returns the old word together with a pass flag. A compare of 0 with a set of 1 gives the usual lock-acquire primitive.

Cross-port atomicity comes from a per-port reservation. While a port's test-and-set is in flight, its address is held in a reservation register. A test-and-set from the other port to that address is refused with a one-cycle busy pulse, and the requester retries later. A plain write from the other port to that address is held off until the reservation clears. When both ports start a test-and-set on one address in the same cycle, port 0 has priority.

Each port controller is a two-state machine:
- **ST_IDLE** accepts a request. It takes transition *accept_tas* to **ST_EVAL**, or it stays idle after a read, a write, a refusal or a stall.
- **ST_EVAL** performs the conditional write and the response, then takes transition *finish* back to **ST_IDLE**.

Top module: `tas_dpram`

## Requirements
- R1: After reset no done or busy pulse is present and every word reads as 0.
- R2: A read (op code 1) accepted at a clock edge gives a done pulse after that edge, carrying the stored word on rdata. Every done pulse follows a cycle in which the port presented a non-idle op.
- R3: A write (op code 2) to an unreserved address stores wdata at the accepting edge and pulses done after it.
- R4: A test-and-set (op code 3) accepted at edge k pulses done after edge k+1, with rdata equal to the word held before the operation. When that word equals cmp, pass is 1 and the location takes wdata at edge k+1. The port's reservation lasts exactly the one cycle between those two edges.
- R5: When the stored word differs from cmp, pass is 0 and the location keeps its contents.
- R6: A test-and-set to an address reserved by the other port gets a busy pulse instead of done, and it changes no memory. Busy is only ever given in reply to a test-and-set, and the two ports never reserve one address at once.
- R7: When both ports start a test-and-set on the same address in the same cycle, port 0 proceeds and port 1 gets busy.
- R8: A plain write from the other port to a reserved address is stalled, including in the cycle the reservation is taken. It completes one edge after the reservation ends, so its data is the last word written.
- R9: Once the reservation's done has been given, a test-and-set from the other port to that address succeeds.
- R10: Test-and-sets from both ports to different addresses in the same cycle both complete in two edges.
- R11: For each port, done and busy are never high in the same cycle.
- R12: Two plain writes to one address at the same edge leave port 0's data in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_op | input | 2 | Port 0 op: 0 idle, 1 read, 2 write, 3 test-and-set; held until done or busy |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data, or set word for test-and-set |
| p0_cmp | input | DW | Port 0 compare word |
| p0_done | output | 1 | Port 0 completion pulse |
| p0_busy | output | 1 | Port 0 test-and-set refused, retry |
| p0_pass | output | 1 | Port 0 test result, valid with done |
| p0_rdata | output | DW | Port 0 read word or old word |
| p1_op | input | 2 | Port 1 op, same encoding |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write or set word |
| p1_cmp | input | DW | Port 1 compare word |
| p1_done | output | 1 | Port 1 completion pulse |
| p1_busy | output | 1 | Port 1 test-and-set refused, retry |
| p1_pass | output | 1 | Port 1 test result |
| p1_rdata | output | DW | Port 1 read word or old word |

## Verification
Suppose a reservation is dropped too early or matched against the wrong address. A conflicting test-and-set or write from the other port then completes within one cycle, where a busy pulse or a stall was due. The bench model sees that missing busy, or the early done, in that same cycle. A wrong captured old word or a wrong compare result shows on rdata and pass at the done pulse. A lost or misplaced conditional write shows at the next read of that location. Random traffic confined to four addresses keeps both ports colliding, so priority and stall errors show up within a few cycles.

// File: rtl/tas_pkg.sv
package tas_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_TAS   = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } pst_e;
endpackage

// File: rtl/tas_mem_core.sv
module tas_mem_core #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int NP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          we,
    input  logic [NP-1:0][AW-1:0]  waddr,
    input  logic [NP-1:0][DW-1:0]  wdata,
    input  logic [NP-1:0][AW-1:0]  raddr,
    output logic [NP-1:0][DW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Highest port index applied first, so port 0 lands last and wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else begin
            for (int p = NP - 1; p >= 0; p--) begin
                if (we[p]) store[waddr[p]] <= wdata[p];
            end
        end
    end

    generate
        for (genvar g = 0; g < NP; g++) begin : g_rd
            assign rdata[g] = store[raddr[g]];
        end
    endgenerate
endmodule

// File: rtl/tas_arbiter.sv
module tas_arbiter import tas_pkg::*; #(
    parameter int AW = 4
) (
    input  logic [1:0]          idle,
    input  logic [1:0][1:0]     op,
    input  logic [1:0][AW-1:0]  addr,
    input  logic [1:0]          rsv_v,
    input  logic [1:0][AW-1:0]  rsv_a,
    output logic [1:0]          go,
    output logic [1:0]          refuse
);
    logic [1:0] hit, claim, blk, is_rd, is_wr, is_tas;
    logic       same_addr;

    assign same_addr = (addr[0] == addr[1]);

    always_comb begin
        for (int p = 0; p < 2; p++) begin
            is_rd[p]  = idle[p] && (op_e'(op[p]) == OP_READ);
            is_wr[p]  = idle[p] && (op_e'(op[p]) == OP_WRITE);
            is_tas[p] = idle[p] && (op_e'(op[p]) == OP_TAS);
            hit[p]    = rsv_v[1-p] && (rsv_a[1-p] == addr[p]);
        end
        // fixed priority: port 0 claims first
        claim[0] = is_tas[0] && !hit[0];
        claim[1] = is_tas[1] && !hit[1] && !(claim[0] && same_addr);
        blk[0]   = hit[0] || (claim[1] && same_addr);
        blk[1]   = hit[1] || (claim[0] && same_addr);
        for (int p = 0; p < 2; p++) begin
            go[p]     = is_rd[p] || (is_wr[p] && !blk[p]) || claim[p];
            refuse[p] = is_tas[p] && !claim[p];
        end
    end
endmodule

// File: rtl/tas_port_ctrl.sv
module tas_port_ctrl import tas_pkg::*; #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] req_cmp,
    input  logic          go,
    input  logic          refuse,
    input  logic [DW-1:0] rd_word,
    output logic          idle,
    output logic          rsv_valid,
    output logic [AW-1:0] rsv_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic          busy,
    output logic          pass,
    output logic [DW-1:0] rdata
);
    pst_e          state_q, state_d;
    op_e           op;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] old_q, cmp_q, set_q;
    logic          match;

    assign op    = op_e'(req_op);
    assign match = (old_q == cmp_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept_tas, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go && op == OP_TAS) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand capture at accept_tas
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            old_q  <= '0;
            cmp_q  <= '0;
            set_q  <= '0;
        end else if (state_q == ST_IDLE && go && op == OP_TAS) begin
            addr_q <= req_addr;
            old_q  <= rd_word;
            cmp_q  <= req_cmp;
            set_q  <= req_wdata;
        end
    end

    assign idle      = (state_q == ST_IDLE);
    assign rsv_valid = (state_q == ST_EVAL);
    assign rsv_addr  = addr_q;

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = req_addr;
        wr_data = req_wdata;
        unique case (state_q)
            ST_IDLE: wr_en = go && (op == OP_WRITE);
            ST_EVAL: begin
                wr_en   = match;
                wr_addr = addr_q;
                wr_data = set_q;
            end
            default: wr_en = 1'b0;
        endcase
    end

    // response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            busy  <= 1'b0;
            pass  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            busy <= 1'b0;
            pass <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go && op == OP_READ) begin
                        done  <= 1'b1;
                        rdata <= rd_word;
                    end
                    if (go && op == OP_WRITE) done <= 1'b1;
                    if (refuse) busy <= 1'b1;
                end
                ST_EVAL: begin
                    done  <= 1'b1;
                    pass  <= match;
                    rdata <= old_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tas_dpram.sv
module tas_dpram #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    p0_op,
    input  logic [AW-1:0] p0_addr,
    input  logic [DW-1:0] p0_wdata,
    input  logic [DW-1:0] p0_cmp,
    output logic          p0_done,
    output logic          p0_busy,
    output logic          p0_pass,
    output logic [DW-1:0] p0_rdata,
    input  logic [1:0]    p1_op,
    input  logic [AW-1:0] p1_addr,
    input  logic [DW-1:0] p1_wdata,
    input  logic [DW-1:0] p1_cmp,
    output logic          p1_done,
    output logic          p1_busy,
    output logic          p1_pass,
    output logic [DW-1:0] p1_rdata
);
    localparam int NP = 2;

    logic [NP-1:0][1:0]    op_a;
    logic [NP-1:0][AW-1:0] addr_a, rsv_a, wa;
    logic [NP-1:0][DW-1:0] wd_a, cmp_a, wdat, rword, rdata_a;
    logic [NP-1:0]         idle, rsv_v, go, refuse, we;
    logic [NP-1:0]         done_a, busy_a, pass_a;

    assign op_a   = {p1_op, p0_op};
    assign addr_a = {p1_addr, p0_addr};
    assign wd_a   = {p1_wdata, p0_wdata};
    assign cmp_a  = {p1_cmp, p0_cmp};

    tas_arbiter #(.AW(AW)) u_arb (
        .idle   (idle),
        .op     (op_a),
        .addr   (addr_a),
        .rsv_v  (rsv_v),
        .rsv_a  (rsv_a),
        .go     (go),
        .refuse (refuse)
    );

    generate
        for (genvar g = 0; g < NP; g++) begin : g_port
            tas_port_ctrl #(.AW(AW), .DW(DW)) u_port (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_op    (op_a[g]),
                .req_addr  (addr_a[g]),
                .req_wdata (wd_a[g]),
                .req_cmp   (cmp_a[g]),
                .go        (go[g]),
                .refuse    (refuse[g]),
                .rd_word   (rword[g]),
                .idle      (idle[g]),
                .rsv_valid (rsv_v[g]),
                .rsv_addr  (rsv_a[g]),
                .wr_en     (we[g]),
                .wr_addr   (wa[g]),
                .wr_data   (wdat[g]),
                .done      (done_a[g]),
                .busy      (busy_a[g]),
                .pass      (pass_a[g]),
                .rdata     (rdata_a[g])
            );
        end
    endgenerate

    tas_mem_core #(.AW(AW), .DW(DW), .NP(NP)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (wa),
        .wdata (wdat),
        .raddr (addr_a),
        .rdata (rword)
    );

    assign p0_done  = done_a[0];
    assign p0_busy  = busy_a[0];
    assign p0_pass  = pass_a[0];
    assign p0_rdata = rdata_a[0];
    assign p1_done  = done_a[1];
    assign p1_busy  = busy_a[1];
    assign p1_pass  = pass_a[1];
    assign p1_rdata = rdata_a[1];
endmodule

// File: rtl/tas_dpram_chk.sv
module tas_dpram_chk #(
    parameter int AW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           p0_op,
    input logic [1:0]           p1_op,
    input logic                 p0_done,
    input logic                 p0_busy,
    input logic                 p1_done,
    input logic                 p1_busy,
    input logic [1:0]           rsv_v,
    input logic [1:0][AW-1:0]   rsv_a
);
    AST_DONE_BUSY_EXCL_P0: assert property (@(posedge clk) disable iff (!rst_n) !(p0_done && p0_busy)); // R11
    AST_DONE_BUSY_EXCL_P1: assert property (@(posedge clk) disable iff (!rst_n) !(p1_done && p1_busy)); // R11
    AST_RSV_NO_SHARE: assert property (@(posedge clk) disable iff (!rst_n) !(rsv_v[0] && rsv_v[1] && rsv_a[0] == rsv_a[1])); // R6
    AST_RSV_ENDS_P0: assert property (@(posedge clk) disable iff (!rst_n) rsv_v[0] |=> (p0_done && !rsv_v[0])); // R4
    AST_RSV_ENDS_P1: assert property (@(posedge clk) disable iff (!rst_n) rsv_v[1] |=> (p1_done && !rsv_v[1])); // R4
    AST_BUSY_FROM_TAS_P0: assert property (@(posedge clk) disable iff (!rst_n) p0_busy |-> $past(p0_op) == 2'd3); // R6
    AST_BUSY_FROM_TAS_P1: assert property (@(posedge clk) disable iff (!rst_n) p1_busy |-> $past(p1_op) == 2'd3); // R6
    AST_DONE_FROM_REQ_P0: assert property (@(posedge clk) disable iff (!rst_n) p0_done |-> $past(p0_op) != 2'd0); // R2
    AST_DONE_FROM_REQ_P1: assert property (@(posedge clk) disable iff (!rst_n) p1_done |-> $past(p1_op) != 2'd0); // R2
endmodule

bind tas_dpram tas_dpram_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .p0_op   (p0_op),
    .p1_op   (p1_op),
    .p0_done (p0_done),
    .p0_busy (p0_busy),
    .p1_done (p1_done),
    .p1_busy (p1_busy),
    .rsv_v   (rsv_v),
    .rsv_a   (rsv_a)
);

// File: tb/tas_dpram_tb.sv
`timescale 1ns/1ps
module tas_dpram_tb;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]    b_op   [2];
    logic [AW-1:0] b_addr [2];
    logic [DW-1:0] b_wd   [2];
    logic [DW-1:0] b_cmp  [2];
    logic [1:0]    done_w, busy_w, pass_w;
    logic [DW-1:0] rd_w [2];

    tas_dpram #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .p0_op(b_op[0]), .p0_addr(b_addr[0]), .p0_wdata(b_wd[0]), .p0_cmp(b_cmp[0]),
        .p0_done(done_w[0]), .p0_busy(busy_w[0]), .p0_pass(pass_w[0]), .p0_rdata(rd_w[0]),
        .p1_op(b_op[1]), .p1_addr(b_addr[1]), .p1_wdata(b_wd[1]), .p1_cmp(b_cmp[1]),
        .p1_done(done_w[1]), .p1_busy(busy_w[1]), .p1_pass(pass_w[1]), .p1_rdata(rd_w[1])
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural reference model, evaluated at each rising edge
    int mem_m [DEPTH];
    bit pend [2];
    int p_addr [2], p_old [2], p_cmp [2], p_set [2];
    bit e_done [2], e_busy [2], e_pass [2], e_chkd [2];
    int e_rd [2];

    always @(posedge clk) begin : model
        bit n_pend [2];
        bit hit [2], claim [2], blk [2];
        int wq_a [$], wq_d [$];
        int a [2];
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_m[i] = 0;
            for (int p = 0; p < 2; p++) begin
                pend[p] = 0; e_done[p] = 0; e_busy[p] = 0; e_pass[p] = 0; e_chkd[p] = 0; e_rd[p] = 0;
            end
        end else begin
            wq_a.delete(); wq_d.delete();
            for (int p = 0; p < 2; p++) begin
                a[p] = int'(b_addr[p]);
                e_done[p] = 0; e_busy[p] = 0; e_pass[p] = 0; e_chkd[p] = 0;
                n_pend[p] = 0;
            end
            for (int p = 0; p < 2; p++) hit[p] = pend[1-p] && p_addr[1-p] == a[p];
            claim[0] = !pend[0] && b_op[0] == 2'd3 && !hit[0];
            claim[1] = !pend[1] && b_op[1] == 2'd3 && !hit[1] && !(claim[0] && a[0] == a[1]);
            blk[0] = hit[0] || (claim[1] && a[0] == a[1]);
            blk[1] = hit[1] || (claim[0] && a[0] == a[1]);
            for (int p = 0; p < 2; p++) begin
                if (pend[p]) begin
                    e_done[p] = 1; e_chkd[p] = 1; e_rd[p] = p_old[p];
                    e_pass[p] = (p_old[p] == p_cmp[p]);
                    if (e_pass[p]) begin wq_a.push_back(p_addr[p]); wq_d.push_back(p_set[p]); end
                end
            end
            for (int p = 1; p >= 0; p--) begin
                if (!pend[p]) begin
                    case (b_op[p])
                        2'd1: begin e_done[p] = 1; e_chkd[p] = 1; e_rd[p] = mem_m[a[p]]; end
                        2'd2: if (!blk[p]) begin
                            e_done[p] = 1;
                            wq_a.push_back(a[p]); wq_d.push_back(int'(b_wd[p]));
                        end
                        2'd3: if (claim[p]) begin
                            n_pend[p] = 1; p_addr[p] = a[p]; p_old[p] = mem_m[a[p]];
                            p_cmp[p] = int'(b_cmp[p]); p_set[p] = int'(b_wd[p]);
                        end else e_busy[p] = 1;
                        default: ;
                    endcase
                end
            end
            for (int i = 0; i < wq_a.size(); i++) mem_m[wq_a[i]] = wq_d[i];
            for (int p = 0; p < 2; p++) pend[p] = n_pend[p];
        end
    end

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // model comparison on every clock
    always @(negedge clk) begin
        if (!finished) begin
            for (int p = 0; p < 2; p++) begin
                check($sformatf("R11 port%0d done", p), int'(done_w[p]), int'(e_done[p]));
                check($sformatf("R6 port%0d busy", p), int'(busy_w[p]), int'(e_busy[p]));
                if (e_done[p]) check($sformatf("R4 port%0d pass", p), int'(pass_w[p]), int'(e_pass[p]));
                if (e_done[p] && e_chkd[p]) check($sformatf("R2 port%0d rdata", p), int'(rd_w[p]), e_rd[p]);
            end
        end
    end

    int last_rd [2], last_pass [2], last_done_cyc [2];
    bit last_busy [2];

    task automatic tick();
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            if (done_w[p]) begin
                last_rd[p] = int'(rd_w[p]); last_pass[p] = int'(pass_w[p]); last_done_cyc[p] = cyc;
            end
            if (busy_w[p]) last_busy[p] = 1;
            if (b_op[p] != 2'd0 && (done_w[p] || busy_w[p])) b_op[p] = 2'd0;
        end
    endtask

    task automatic issue(int p, int op, int addr, int wd, int cmp);
        b_op[p] = op[1:0]; b_addr[p] = addr[AW-1:0]; b_wd[p] = wd[DW-1:0]; b_cmp[p] = cmp[DW-1:0];
        last_busy[p] = 0; last_done_cyc[p] = -1;
    endtask

    task automatic quiet();
        int n = 0;
        do begin tick(); n++; end while ((b_op[0] != 2'd0 || b_op[1] != 2'd0) && n < 50);
    endtask

    task automatic rd(int p, int addr, output int val);
        issue(p, 1, addr, 0, 0); quiet(); val = last_rd[p];
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int v, c0;
        for (int p = 0; p < 2; p++) begin
            b_op[p] = 0; b_addr[p] = 0; b_wd[p] = 0; b_cmp[p] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R1 done idle", int'(done_w), 0);
        check("R1 busy idle", int'(busy_w), 0);
        rd(1, 3, v); check("R1 read zero", v, 0);

        issue(0, 2, 2, 'h1234, 0); quiet();
        rd(1, 2, v); check("R3 write then read", v, 'h1234);
        rd(0, 2, v); check("R2 read port0", v, 'h1234);

        c0 = cyc; issue(0, 3, 5, 1, 0); quiet();
        check("R4 done latency", last_done_cyc[0] - c0, 2);
        check("R4 pass", last_pass[0], 1);
        check("R4 old value", last_rd[0], 0);
        rd(1, 5, v); check("R4 set applied", v, 1);

        issue(1, 3, 5, 7, 0); quiet();
        check("R5 fail flag", last_pass[1], 0);
        check("R5 old value", last_rd[1], 1);
        rd(0, 5, v); check("R5 unchanged", v, 1);

        issue(0, 3, 8, 1, 0); tick(); issue(1, 3, 8, 0, 1); quiet();
        check("R6 refused", int'(last_busy[1]), 1);
        rd(1, 8, v); check("R6 memory from owner only", v, 1);
        issue(1, 3, 8, 0, 1); quiet();
        check("R9 retry succeeds", last_pass[1], 1);
        rd(0, 8, v); check("R9 retry wrote", v, 0);

        issue(0, 3, 9, 1, 0); issue(1, 3, 9, 2, 0); quiet();
        check("R7 port0 wins", last_pass[0], 1);
        check("R7 port1 busy", int'(last_busy[1]), 1);
        rd(1, 9, v); check("R7 memory", v, 1);

        c0 = cyc; issue(0, 3, 10, 5, 0); tick(); issue(1, 2, 10, 'h77, 0); quiet();
        check("R8 stalled write timing", last_done_cyc[1] - c0, 3);
        rd(0, 10, v); check("R8 write lands last", v, 'h77);
        c0 = cyc; issue(0, 3, 14, 1, 0); issue(1, 2, 14, 'h55, 0); quiet();
        check("R8 same-cycle write timing", last_done_cyc[1] - c0, 3);
        rd(1, 14, v); check("R8 same-cycle final", v, 'h55);

        c0 = cyc; issue(0, 3, 11, 3, 0); issue(1, 3, 12, 4, 0); quiet();
        check("R10 port0 latency", last_done_cyc[0] - c0, 2);
        check("R10 port1 latency", last_done_cyc[1] - c0, 2);
        check("R10 both pass", last_pass[0] + last_pass[1], 2);

        issue(0, 2, 13, 'hAAAA, 0); issue(1, 2, 13, 'hBBBB, 0); quiet();
        rd(1, 13, v); check("R12 port0 data kept", v, 'hAAAA);

        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < 2; p++) begin
                if (b_op[p] == 2'd0 && ($urandom % 3) != 0)
                    issue(p, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                          int'($urandom % 4));
            end
            tick();
        end
        quiet();
        finish_run();
    end
endmodule